// File: doc/BRIEF.md
# APB Bus Activity Classifier Counters

A passive observer attached to the select, enable and write-direction wires of an APB segment. It never drives the bus. On every rising clock edge outside reset it sorts the cycle into one of three command classes. It measures how long the select line stays high and files each complete run under a transfer-length bin. It times the low gaps between enable pulses. It also records the write/read direction sequence across consecutive access phases. Every statistic sits in its own saturating counter.

Software or a debug path reads the counters through a small combinational read port: an index goes in and that counter's value comes out in the same cycle. Reset clears every counter and all history. A run, gap or direction pair therefore never straddles a reset.

Top module: `apb_activity_counters`

## Requirements
- R1: Each sampled cycle increments exactly one of three counters: index 0 when select=1 and write=1, index 1 when select=1 and write=0, index 2 when select=0.
- R2: A select-high run of exactly 2 cycles, with a sampled 0 before it and after it, increments index 3 (single transfer) in the cycle where the closing 0 is sampled.
- R3: A framed select-high run of 2N cycles increments index 4, 5, 6, 7 or 8 for N = 2, 4, 8, 16 or 32 respectively.
- R4: A framed select-high run of any other length, including runs longer than 64 cycles, increments index 9.
- R5: A select-high run that has no sampled 0 before it since reset is not classified by any of indices 3 to 9.
- R6: An enable pattern of high, exactly one low sample, then high increments index 10 (back-to-back) when the second high is sampled.
- R7: An enable gap of 2 to 10 low samples between two highs increments index 11 (separated). Longer gaps increment neither index 10 nor index 11.
- R8: Each sample with enable=1, apart from the first one after reset, increments one ordering counter chosen by the previous and current write values: index 12 write→write, 13 write→read, 14 read→write, 15 read→read.
- R9: Every counter is CNT_W bits wide and holds at 2^CNT_W−1 instead of wrapping.
- R10: Reset clears all counters, the run and gap history, and the previous-direction history.
- R11: rd_data equals the counter selected by rd_addr, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_sel | input | 1 | Observed bus select |
| mon_en | input | 1 | Observed bus enable |
| mon_wr | input | 1 | Observed bus write direction |
| rd_addr | input | 4 | Counter index to read |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Two situations are hard to reach from the ports. The first is a select run left unframed by reset. The bench holds select high across the reset release, so the first sampled value is already 1, and then confirms that no length bin moves while the command counter still does. The second is the edge of the gap window. Idle stretches of 9 and 10 cycles after a transfer yield enable gaps of 10 and 11 samples, which land just inside and just outside the separated window. Saturation comes from running several hundred single transfers against an 8-bit counter build.

// File: rtl/apb_activity_counters.sv
module apb_activity_counters #(
  parameter int CNT_W = 16,
  parameter int RUN_W = 7,
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_sel,
  input  logic             mon_en,
  input  logic             mon_wr,
  input  logic [3:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int NCNT = 16;
  localparam int NBIN = 6;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [RUN_W-1:0] RMAX = '1;
  localparam logic [GAP_W-1:0] GMAX = '1;

  logic             prev_sel, run_ok;
  logic [RUN_W-1:0] run_len;
  logic             hi_seen;
  logic [GAP_W-1:0] gap;
  logic             prev_wr, wr_seen;
  logic [NCNT-1:0]  bump;
  logic [CNT_W-1:0] cnt [NCNT];

  wire run_end = !mon_sel && prev_sel && run_ok;

  always_comb begin
    bump = '0;
    bump[0] = mon_sel && mon_wr;
    bump[1] = mon_sel && !mon_wr;
    bump[2] = !mon_sel;
    if (run_end) begin
      bump[9] = 1'b1;
      for (int k = 0; k < NBIN; k++)
        if (run_len == RUN_W'(2 << k)) begin
          bump[3+k] = 1'b1;
          bump[9]   = 1'b0;
        end
    end
    if (mon_en && hi_seen) begin
      bump[10] = (gap == GAP_W'(1));
      bump[11] = (gap >= GAP_W'(2)) && (gap <= GAP_W'(10));
    end
    if (mon_en && wr_seen)
      case ({prev_wr, mon_wr})
        2'b11:   bump[12] = 1'b1;
        2'b10:   bump[13] = 1'b1;
        2'b01:   bump[14] = 1'b1;
        default: bump[15] = 1'b1;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel <= 1'b1;
      run_ok   <= 1'b0;
      run_len  <= '0;
      hi_seen  <= 1'b0;
      gap      <= '0;
      prev_wr  <= 1'b0;
      wr_seen  <= 1'b0;
    end else begin
      prev_sel <= mon_sel;
      if (mon_sel && !prev_sel) begin
        run_len <= RUN_W'(1);
        run_ok  <= 1'b1;
      end else if (mon_sel && run_len != RMAX) begin
        run_len <= run_len + 1'b1;
      end
      if (mon_en) begin
        hi_seen <= 1'b1;
        gap     <= '0;
        prev_wr <= mon_wr;
        wr_seen <= 1'b1;
      end else if (gap != GMAX) begin
        gap <= gap + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt[i] <= '0;
      else if (bump[i] && cnt[i] != CMAX) cnt[i] <= cnt[i] + 1'b1;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] == CMAX) |=> (cnt[i] == CMAX));
  end

  assign rd_data = cnt[rd_addr];

  a_r1_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bump[2:0]) == 1);

  a_r3_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bump[9:3]));

  a_r2_bin_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (|bump[9:3]) |-> (!mon_sel && $past(mon_sel)));

  a_r6_b2b_shape: assert property (@(posedge clk) disable iff (!rst_n)
    bump[10] |-> (mon_en && !$past(mon_en) && $past(mon_en, 2)));

  a_r7_gap_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bump[10] && bump[11]));

  a_r8_order_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (|bump[15:12]) |-> (mon_en && $onehot(bump[15:12])));
endmodule

// File: tb/sim_apb_activity_counters.sv
`timescale 1ns/100ps
module sim_apb_activity_counters;
  localparam int W = 8;
  localparam int CMAXI = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mon_sel = 1'b0, mon_en = 1'b0, mon_wr = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [W-1:0] rd_data;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;
  int expv [16];
  bit have_prev;
  bit last_wr;
  int last_g;

  apb_activity_counters #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mon_sel(mon_sel), .mon_en(mon_en),
    .mon_wr(mon_wr), .rd_addr(rd_addr), .rd_data(rd_data));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc_cnt);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic cyc(input bit s, input bit e, input bit w);
    mon_sel = s; mon_en = e; mon_wr = w;
    @(negedge clk);
  endtask

  task automatic idle(input int g);
    for (int i = 0; i < g; i++) cyc(0, 0, 0);
    expv[2] += g;
    last_g += g;
  endtask

  task automatic do_reset(input bit s);
    mon_sel = s; mon_en = 1'b0; mon_wr = s;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) expv[i] = 0;
    have_prev = 0; last_wr = 0; last_g = 0;
  endtask

  function automatic string req_of(input int a);
    if (a < 3)  return "R1";
    if (a == 3) return "R2";
    if (a < 9)  return "R3";
    if (a == 9) return "R4";
    if (a == 10) return "R6";
    if (a == 11) return "R7";
    return "R8";
  endfunction

  task automatic check_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      int e;
      string r;
      rd_addr = 4'(a);
      #0.2;
      e = (expv[a] > CMAXI) ? CMAXI : expv[a];
      r = (expv[a] > CMAXI) ? "R9" : req_of(a);
      if (tag != "") r = {r, "/", tag};
      n_run++;
      if (int'(rd_data) != e) begin
        n_fail++;
        $display("FAIL %s R11 counter %0d: actual %0d expected %0d", r, a, rd_data, e);
      end
    end
  endtask

  // n beats, beat i write direction = wm[i], then g idle cycles (g >= 1)
  task automatic xfer(input int n, input logic [63:0] wm, input int g);
    int nw;
    int gapv;
    nw = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, wm[i]);
      cyc(1, 1, wm[i]);
      if (wm[i]) nw++;
    end
    expv[0] += 2 * nw;
    expv[1] += 2 * (n - nw);
    case (n)
      1:  expv[3]++;
      2:  expv[4]++;
      4:  expv[5]++;
      8:  expv[6]++;
      16: expv[7]++;
      32: expv[8]++;
      default: expv[9]++;
    endcase
    expv[10] += n - 1;
    gapv = last_g + 1;
    if (have_prev && gapv >= 2 && gapv <= 10) expv[11]++;
    for (int i = 0; i < n; i++) begin
      bit p;
      p = (i == 0) ? last_wr : wm[i-1];
      if (i > 0 || have_prev)
        expv[12 + 2 * int'(!p) + int'(!wm[i])]++;
    end
    have_prev = 1;
    last_wr = wm[n-1];
    last_g = 0;
    idle(g);
  endtask

  initial begin
    @(negedge clk);
    do_reset(0);
    check_all("R10");                       // reset state
    idle(3);
    xfer(1, 64'h1, 2);   check_all("");     // R2 single write
    xfer(1, 64'h0, 1);   check_all("");     // R7 gap 3
    xfer(2, 64'h1, 4);   check_all("");     // R3 N=2
    xfer(4, 64'hA, 1);   check_all("");     // R8 mixed order
    xfer(8, 64'h0F, 2);  check_all("");
    xfer(16, 64'h5555, 1); check_all("");
    xfer(32, 64'hF0F0_3C3C, 3); check_all("");
    xfer(3, 64'h2, 9);   check_all("");     // R4 length 6
    xfer(1, 64'h1, 10);  check_all("");     // R7 gap 10 counts
    xfer(40, 64'hFF_0000_FFFF, 1); check_all(""); // R4 run 80, gap 11 ignored
    xfer(5, 64'h1F, 2);  check_all("");

    do_reset(1);                            // R5 select high across reset
    cyc(1, 0, 1); cyc(1, 0, 1);
    expv[0] += 2;
    idle(3);
    check_all("R5");
    xfer(1, 64'h0, 1);   check_all("R10");  // first enable after reset: no pair

    for (int k = 0; k < 300; k++) xfer(1, 64'(k % 3 == 0), 1);
    check_all("R9");
    idle(300);
    check_all("R9");

    do_reset(0);
    cyc(0, 0, 0);
    expv[2] += 1;
    check_all("R10");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule